// File: doc/BRIEF.md
# DMA Channel Sync and Drop Status Tracker

This block is the per-channel control logic that follows hardware synchronization requests in a DMA controller. When the channel is enabled, a request pulse sets a pending flag. The flag stays set until the channel reports that the first read from the source into the channel buffer has completed. A request that arrives while the flag is still set is an overrun. It is not queued. Instead the channel is told to stop: its enable bit drops at the next element boundary, so the element already in flight finishes cleanly.

Two event status bits report overruns and element completions. Each bit is set only when its own interrupt enable is high. The whole event status word clears when software reads it. The interrupt request is a level signal. It is high while any status bit is set whose enable is currently high.

Software re-arms a stopped channel by writing the enable bit. That write also cancels any pending shutdown. Address generation, the data path, port arbitration and bus protocol sit outside this block.

Top module: `dma_sync_tracker`

## Requirements
- R1: While `ch_en_o` is 1 and `sync_flag_o` is 0, a pulse on `sync_evt_i` sets `sync_flag_o` on the next clock edge.
- R2: A pulse on `src_rd_done_i` clears `sync_flag_o` on the next edge, unless a new request is accepted in the same cycle.
- R3: A request that arrives while `sync_flag_o` is 1 and no source read completes in that cycle is a drop. It is not queued, so a single source read completion afterwards leaves the flag at 0. A request in the same cycle as a source read completion is accepted, not dropped.
- R4: After a drop, `ch_en_o` stays 1 until the first cycle with `elem_done_i` high, and it is 0 after that edge. When the drop and `elem_done_i` happen in the same cycle, the channel stops at that edge. This happens whatever the interrupt enables are.
- R5: `stat_o[0]` (overrun) is set by a drop only when `ie_i[0]` is 1. With `ie_i[0]` at 0, a drop leaves it unchanged.
- R6: `stat_o[1]` (element done) is set by `elem_done_i` only when `ie_i[1]` is 1. Otherwise it is left unchanged.
- R7: A pulse on `stat_rd_i` clears both bits of `stat_o` on the next edge. A bit that is being set in the same cycle stays set.
- R8: `irq_o` equals the OR over `stat_o & ie_i`. It falls in the cycle after a clearing read.
- R9: While `ch_en_o` is 0, `sync_evt_i` is ignored: it neither sets the flag nor causes a drop.
- R10: When `en_wr_i` is 1, `ch_en_o` takes `en_wdata_i` on the next edge and any pending shutdown is cancelled. The write takes priority over an element-boundary shutdown in the same cycle.
- R11: With `rst_n` low, `ch_en_o`, `sync_flag_o`, `stat_o` and `irq_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_evt_i | input | 1 | Hardware synchronization request pulse |
| src_rd_done_i | input | 1 | First source read after a request has completed |
| elem_done_i | input | 1 | Element transfer finished (element boundary) |
| en_wr_i | input | 1 | Software write strobe for the channel enable |
| en_wdata_i | input | 1 | Value written to the channel enable |
| ie_i | input | 2 | Interrupt enables: bit 0 overrun, bit 1 element done |
| stat_rd_i | input | 1 | Status read strobe (clear on read) |
| ch_en_o | output | 1 | Channel enable |
| sync_flag_o | output | 1 | Request pending (1) or serviced (0) |
| stat_o | output | 2 | Event status: bit 0 overrun, bit 1 element done |
| irq_o | output | 1 | Level interrupt request |

## Verification
The properties assume every strobe is synchronous to `clk` and is sampled for a single cycle. They also assume `src_rd_done_i` reports completion of a read the channel has really issued. The assertions do not model the datapath, so they accept a completion even when no request is pending.

The stimulus changes inputs only on the falling edge and holds them for one full cycle. It puts overlapping strobes on purpose only in the cases the requirements name:
- request together with read completion;
- drop together with element done;
- read together with a status-setting event;
- enable write together with element done.

// File: rtl/dma_sync_pkg.sv
package dma_sync_pkg;
  // Event status bit positions (software decodes these)
  localparam int EV_OVERRUN = 0;
  localparam int EV_ELEM    = 1;
  localparam int EV_W       = 2;
endpackage

// File: rtl/dma_sync_flag.sv
module dma_sync_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_evt_i,
  input  logic src_rd_done_i,
  input  logic ch_en_i,
  output logic flag_o,
  output logic drop_o
);
  logic flag_q, flag_d, flag_ce;
  logic accept;

  // A request is accepted when nothing is pending or the pending one is
  // being serviced in this very cycle.
  always_comb begin
    accept  = ch_en_i & sync_evt_i & (~flag_q | src_rd_done_i);
    drop_o  = ch_en_i & sync_evt_i & flag_q & ~src_rd_done_i;
    flag_ce = accept | src_rd_done_i;
    flag_d  = accept;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (flag_ce) flag_q <= flag_d;
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/dma_en_ctrl.sv
module dma_en_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic drop_i,
  input  logic elem_done_i,
  input  logic en_wr_i,
  input  logic en_wdata_i,
  output logic ch_en_o
);
  logic en_q, en_d, pend_q, pend_d, ce;

  always_comb begin
    en_d   = en_q;
    pend_d = pend_q;
    if (en_wr_i) begin
      en_d   = en_wdata_i;
      pend_d = 1'b0;
    end else if (elem_done_i && (pend_q || drop_i)) begin
      en_d   = 1'b0;
      pend_d = 1'b0;
    end else if (drop_i) begin
      pend_d = 1'b1;
    end
    ce = en_wr_i | elem_done_i | drop_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      pend_q <= 1'b0;
    end else if (ce) begin
      en_q   <= en_d;
      pend_q <= pend_d;
    end
  end

  assign ch_en_o = en_q;
endmodule

// File: rtl/dma_evt_status.sv
module dma_evt_status #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] ie_i,
  input  logic         rd_i,
  output logic [W-1:0] stat_o
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic q, d, ce, hit;
    always_comb begin
      hit = set_i[b] & ie_i[b];
      ce  = hit | rd_i;
      d   = hit;          // set beats the clearing read
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= 1'b0;
      else if (ce) q <= d;
    end
    assign stat_o[b] = q;
  end
endmodule

// File: rtl/dma_sync_tracker.sv
module dma_sync_tracker
  import dma_sync_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sync_evt_i,
  input  logic            src_rd_done_i,
  input  logic            elem_done_i,
  input  logic            en_wr_i,
  input  logic            en_wdata_i,
  input  logic [EV_W-1:0] ie_i,
  input  logic            stat_rd_i,
  output logic            ch_en_o,
  output logic            sync_flag_o,
  output logic [EV_W-1:0] stat_o,
  output logic            irq_o
);
  logic            drop;
  logic [EV_W-1:0] ev_set;

  dma_sync_flag u_flag (
    .clk, .rst_n, .sync_evt_i, .src_rd_done_i,
    .ch_en_i(ch_en_o), .flag_o(sync_flag_o), .drop_o(drop)
  );

  dma_en_ctrl u_en (
    .clk, .rst_n, .drop_i(drop), .elem_done_i,
    .en_wr_i, .en_wdata_i, .ch_en_o
  );

  always_comb begin
    ev_set             = '0;
    ev_set[EV_OVERRUN] = drop;
    ev_set[EV_ELEM]    = elem_done_i;
  end

  dma_evt_status #(.W(EV_W)) u_stat (
    .clk, .rst_n, .set_i(ev_set), .ie_i, .rd_i(stat_rd_i), .stat_o
  );

  assign irq_o = |(stat_o & ie_i);
endmodule

// File: rtl/dma_sync_tracker_chk.sv
module dma_sync_tracker_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sync_evt_i,
  input logic       src_rd_done_i,
  input logic       elem_done_i,
  input logic       en_wr_i,
  input logic       en_wdata_i,
  input logic [1:0] ie_i,
  input logic       stat_rd_i,
  input logic       ch_en_o,
  input logic       sync_flag_o,
  input logic [1:0] stat_o,
  input logic       irq_o
);
  AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    ch_en_o && !sync_flag_o && sync_evt_i |=> sync_flag_o); // R1
  AST_FLAG_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    sync_flag_o && src_rd_done_i && !sync_evt_i |=> !sync_flag_o); // R2
  AST_DROP_KEEP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    sync_flag_o && sync_evt_i && !src_rd_done_i |=> sync_flag_o); // R3
  AST_DROP_HOLD_EN: assert property (@(posedge clk) disable iff (!rst_n)
    ch_en_o && sync_flag_o && sync_evt_i && !src_rd_done_i && !elem_done_i && !en_wr_i
    |=> ch_en_o); // R4
  AST_DROP_STAT: assert property (@(posedge clk) disable iff (!rst_n)
    ch_en_o && sync_flag_o && sync_evt_i && !src_rd_done_i && ie_i[0] |=> stat_o[0]); // R5
  AST_OVR_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_o[0] && !ie_i[0] |=> !stat_o[0]); // R5
  AST_ELEM_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_o[1] && !ie_i[1] |=> !stat_o[1]); // R6
  AST_RD_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd_i && !(elem_done_i && ie_i[1]) |=> !stat_o[1]); // R7
  AST_IRQ_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> stat_o != 2'b00); // R8
  AST_OFF_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
    !ch_en_o && !sync_flag_o && sync_evt_i |=> !sync_flag_o); // R9
  AST_EN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    en_wr_i |=> ch_en_o == $past(en_wdata_i)); // R10
endmodule

bind dma_sync_tracker dma_sync_tracker_chk u_chk (.*);

// File: tb/sim_dma_sync_tracker.sv
module sim_dma_sync_tracker;
  localparam time CLK_PERIOD = 10ns;
  localparam int  NVEC = 27;

  // in: sync rdd eld enwr enwd ie1 ie0 rd | exp: en flag s1 s0 irq
  localparam logic [12:0] VEC [NVEC] = '{
    13'b0001_1110_1_0_00_0, // 1  R10 enable
    13'b1000_0110_1_1_00_0, // 2  R1 accept
    13'b0100_0110_1_0_00_0, // 3  R2 service
    13'b1000_0110_1_1_00_0, // 4  R1
    13'b1100_0110_1_1_00_0, // 5  R3 same-cycle accept
    13'b0010_0110_1_1_10_1, // 6  R6 elem status
    13'b0000_0111_1_1_00_0, // 7  R7 read clears
    13'b1000_0110_1_1_01_1, // 8  R5 drop, en held
    13'b0010_0110_0_1_11_1, // 9  R4 stop at boundary
    13'b0010_0111_0_1_10_1, // 10 R7 set wins over read
    13'b0000_0111_0_1_00_0, // 11 R8 irq falls
    13'b1000_0110_0_1_00_0, // 12 R9 ignored while off
    13'b0100_0110_0_0_00_0, // 13 R2
    13'b1000_0110_0_0_00_0, // 14 R9
    13'b0001_1110_1_0_00_0, // 15 R10
    13'b1000_0000_1_1_00_0, // 16 R1
    13'b1000_0000_1_1_00_0, // 17 R5 drop without IE
    13'b0010_0000_0_1_00_0, // 18 R4 stop without IE
    13'b0001_1110_1_1_00_0, // 19 R10
    13'b1010_0110_0_1_11_1, // 20 R4 drop with elem done
    13'b0000_0111_0_1_00_0, // 21 R7
    13'b0001_1010_1_1_00_0, // 22 R10
    13'b1000_0010_1_1_01_1, // 23 R5
    13'b0011_1010_1_1_01_1, // 24 R10 write beats shutdown, R6 gated
    13'b0010_0010_1_1_01_1, // 25 R10 pending cancelled
    13'b0000_0000_1_1_01_0, // 26 R8 masked by ie
    13'b0000_0001_1_1_00_0  // 27 R7
  };

  logic clk = 1'b0;
  logic rst_n;
  logic sync_evt_i, src_rd_done_i, elem_done_i, en_wr_i, en_wdata_i, stat_rd_i;
  logic [1:0] ie_i;
  logic ch_en_o, sync_flag_o, irq_o;
  logic [1:0] stat_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_sync_tracker u0 (.*);

  function automatic string req_of(int i);
    case (i + 1)
      1, 15, 19, 22, 24, 25: return "R10";
      2, 4, 16:              return "R1";
      3, 13:                 return "R2";
      5:                     return "R3";
      6:                     return "R6";
      7, 10, 21, 27:         return "R7";
      8, 17, 23:             return "R5";
      9, 18, 20:             return "R4";
      11, 26:                return "R8";
      default:               return "R9";
    endcase
  endfunction

  task automatic check(string req, logic [4:0] exp);
    logic [4:0] act;
    act = {ch_en_o, sync_flag_o, stat_o, irq_o};
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: {en,flag,stat,irq} actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic drive(logic [7:0] v);
    {sync_evt_i, src_rd_done_i, elem_done_i, en_wr_i, en_wdata_i, ie_i, stat_rd_i} = v;
  endtask

  task automatic step(logic [7:0] v);
    drive(v);
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0;
    drive(8'h00);
    repeat (2) @(negedge clk);
    check("R11 reset state", 5'b0_0_00_0);
    rst_n = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      step(VEC[i][12:5]);
      check(req_of(i), VEC[i][4:0]);
    end

    // R3: drop is not queued; one service leaves nothing pending
    step(8'b0000_0000);            // idle, flag still 1 from table
    step(8'b0100_0000);            // service
    check("R2 flag cleared", 5'b1_0_00_0);
    step(8'b1000_0110);            // accept
    step(8'b1000_0110);            // drop
    check("R3 drop keeps flag", 5'b1_1_01_1);
    step(8'b0100_0110);            // single service
    check("R3 not queued", 5'b1_0_01_1);
    step(8'b0000_0110);
    check("R3 flag stays clear", 5'b1_0_01_1);
    step(8'b0010_0110);            // boundary -> stop
    check("R4 stop after service", 5'b0_0_11_1);

    // R11: reset mid-operation
    step(8'b0001_1110);
    step(8'b1000_0110);
    #1 rst_n = 1'b0;
    #1 check("R11 async reset clears all", 5'b0_0_00_0);
    @(negedge clk);
    rst_n = 1'b1;
    drive(8'h00);
    step(8'h00);
    check("R11 stays cleared", 5'b0_0_00_0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule